// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns parallel characters into asynchronous serial frames. A write places a character in a holding register. The shift stage takes it from there once the current frame has ended, so software can queue one character ahead. Bit timing comes from an external transmit clock that is sampled in the system clock domain. Each bit lasts 1, 16 or 64 periods of that clock, and bit boundaries follow its falling edges.

Character length, parity and stop length are static inputs. Each frame captures them when its character is loaded. Two control inputs act on the transmitter: an enable and a break request. A clear-to-send input (active low) also gates it. The block drives the serial line, two ready indications and an empty flag. The ready pin version is qualified by enable and clear-to-send. The ready status version shows only whether the holding register is free.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever the transmitter is idle, `txd` is high (marking), `rdy_stat` is 1 and `tx_empty` is 1.
- R2: While `send_brk` is 1, `txd` is held low continuously. Once it is released on an idle transmitter, `txd` returns high.
- R3: One bit lasts F transmit-clock periods, and `baud_sel` picks F: 00 or 01 gives 1, 10 gives 16, 11 gives 64. Bit boundaries follow falling edges of `txc`.
- R4: A frame is one low start bit followed by the data bits, least significant bit first. The number of data bits is 5 + `len_sel` (00 gives 5, 11 gives 8).
- R5: When `par_en` is 1, a parity bit follows the data. With `par_even` = 1 the data and parity bits together hold an even number of ones; with `par_even` = 0 they hold an odd number.
- R6: The stop bits are high and `stop_sel` sets their length: 00 or 01 gives F periods, 10 gives 1.5·F (2 periods when F = 1), 11 gives 2·F. A held character starts on the very edge where the previous stop time ends.
- R7: `rdy_pin` is 1 exactly when the holding register is empty, `tx_en` is 1 and `cts_n` is 0. `rdy_stat` is 1 exactly when the holding register is empty.
- R8: A write (`wr_stb`) clears `rdy_stat` and `rdy_pin` in the next cycle. While the transmitter is enabled, the write also clears `tx_empty`.
- R9: `tx_empty` is 1 when no frame is being shifted and no character is held that could be sent now.
- R10: Deasserting `tx_en`, or raising `cts_n`, during a frame lets that frame finish. The line then stays high and `tx_empty` goes to 1.
- R11: A character written while `tx_en` is 0 or `cts_n` is 1 is not sent until both permit sending again. It is then sent intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txc | input | 1 | Transmit bit-rate clock, asynchronous to clk |
| tx_en | input | 1 | Transmitter enable |
| send_brk | input | 1 | Break request: holds the line low |
| cts_n | input | 1 | Clear to send, active low |
| baud_sel | input | 2 | Periods per bit: 00/01 x1, 10 x16, 11 x64 |
| len_sel | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 for even parity, 0 for odd |
| stop_sel | input | 2 | Stop length: 00/01 one, 10 one and a half, 11 two |
| wr_stb | input | 1 | One-cycle write strobe for a character |
| wr_data | input | DATA_W | Character to send |
| txd | output | 1 | Serial output |
| rdy_pin | output | 1 | Ready, qualified by enable and clear-to-send |
| rdy_stat | output | 1 | Ready, holding register empty |
| tx_empty | output | 1 | Transmitter empty |

## Verification
Two events can fall on the same transmit-clock edge: the end of one frame's stop time and the load of the next held character. The bench provokes this by writing a second character while the first is still shifting. It then measures the time from the first start edge to the second in system cycles. That spacing must equal exactly the frame length it computes from the format, so a lost or added stop period shows up at once. A second overlap is a disable, by enable or by clear-to-send, arriving mid-frame. It is judged by the frame decoding intact and the line then staying marked.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } phase_t;

  // transmit-clock periods per bit for a baud selection
  function automatic int unsigned bit_ticks(input logic [1:0] bsel);
    case (bsel)
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 1;
    endcase
  endfunction

  // stop time in transmit-clock periods
  function automatic int unsigned stop_ticks(input logic [1:0] bsel, input logic [1:0] ssel);
    int unsigned f;
    f = bit_ticks(bsel);
    case (ssel)
      2'b10:   return (f == 1) ? 2 : f + f / 2;
      2'b11:   return 2 * f;
      default: return f;
    endcase
  endfunction

  // data bits in a character
  function automatic int unsigned char_bits(input logic [1:0] lsel);
    return 5 + int'(lsel);
  endfunction

endpackage

// File: rtl/sft_edge.sv
module sft_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic txc,
  output logic fall
);
  logic [SYNC_STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[SYNC_STAGES-1:0], txc};
  end

  assign fall = sr[SYNC_STAGES] & ~sr[SYNC_STAGES-1];

endmodule

// File: rtl/sft_hold.sv
module sft_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst) wr |=> full); // R8
  AST_TAKE_FULL: assert property (@(posedge clk) disable iff (rst) take |-> full); // R4

endmodule

// File: rtl/sft_shift.sv
module sft_shift
  import sft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              go,
  input  logic              avail,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic [1:0]        baud_sel,
  input  logic [1:0]        stop_sel,
  input  logic              brk,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int NBW = $clog2(DATA_W + 1);

  phase_t            phase;
  logic [DATA_W-1:0] sh;
  logic [NBW-1:0]    idx;
  logic [NBW-1:0]    nb;
  logic [TICK_W-1:0] tick;
  logic [TICK_W-1:0] bt;
  logic [TICK_W-1:0] st;
  logic              pen;
  logic              parv;
  logic              par_new;
  logic [TICK_W-1:0] cur_len;
  logic              last_tick;
  int unsigned       n_new;

  assign n_new = char_bits(len_sel);

  always_comb begin
    par_new = ~par_even;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(n_new)) par_new = par_new ^ hold_data[i];
    end
  end

  assign cur_len   = (phase == PH_STOP) ? st : bt;
  assign last_tick = (tick == cur_len - TICK_W'(1));
  assign busy      = (phase != PH_IDLE);
  assign take      = fall & avail & go &
                     ((phase == PH_IDLE) | ((phase == PH_STOP) & last_tick));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      sh    <= '0;
      idx   <= '0;
      nb    <= '0;
      tick  <= '0;
      bt    <= TICK_W'(1);
      st    <= TICK_W'(1);
      pen   <= 1'b0;
      parv  <= 1'b0;
    end else if (take) begin
      phase <= PH_START;
      sh    <= hold_data;
      idx   <= '0;
      nb    <= NBW'(n_new);
      tick  <= '0;
      bt    <= TICK_W'(bit_ticks(baud_sel));
      st    <= TICK_W'(stop_ticks(baud_sel, stop_sel));
      pen   <= par_en;
      parv  <= par_new;
    end else if (fall && busy) begin
      if (last_tick) begin
        tick <= '0;
        case (phase)
          PH_START: begin
            phase <= PH_DATA;
            idx   <= '0;
          end
          PH_DATA: begin
            sh <= sh >> 1;
            if (idx == nb - NBW'(1)) phase <= pen ? PH_PAR : PH_STOP;
            else                     idx   <= idx + NBW'(1);
          end
          PH_PAR:  phase <= PH_STOP;
          default: phase <= PH_IDLE;
        endcase
      end else begin
        tick <= tick + TICK_W'(1);
      end
    end
  end

  always_comb begin
    if (brk) txd = 1'b0;
    else begin
      case (phase)
        PH_START: txd = 1'b0;
        PH_DATA:  txd = sh[0];
        PH_PAR:   txd = parv;
        default:  txd = 1'b1;
      endcase
    end
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst) busy |-> (tick < cur_len)); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst) (phase == PH_DATA) |-> (idx < nb)); // R4
  AST_STOP_TO_START: assert property (@(posedge clk) disable iff (rst)
    (($past(phase) == PH_STOP) && (phase == PH_START)) |-> $past(fall)); // R6

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DATA_W      = 8,
  parameter int TICK_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txc,
  input  logic              tx_en,
  input  logic              send_brk,
  input  logic              cts_n,
  input  logic [1:0]        baud_sel,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic [1:0]        stop_sel,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              rdy_pin,
  output logic              rdy_stat,
  output logic              tx_empty
);
  logic              fall;
  logic              go;
  logic              full;
  logic              take;
  logic              busy;
  logic [DATA_W-1:0] hold_q;

  assign go = tx_en & ~cts_n;

  sft_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .txc(txc), .fall(fall)
  );

  sft_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr(wr_stb), .wr_data(wr_data),
    .take(take), .full(full), .data(hold_q)
  );

  sft_shift #(.DATA_W(DATA_W), .TICK_W(TICK_W)) u_shift (
    .clk(clk), .rst(rst), .fall(fall), .go(go), .avail(full),
    .hold_data(hold_q), .len_sel(len_sel), .par_en(par_en),
    .par_even(par_even), .baud_sel(baud_sel), .stop_sel(stop_sel),
    .brk(send_brk), .take(take), .busy(busy), .txd(txd)
  );

  assign rdy_stat = ~full;
  assign rdy_pin  = ~full & go;
  assign tx_empty = ~busy & (~full | ~go);

  AST_LOAD_GO: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(go)); // R11

endmodule

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;
  localparam int CLK_P = 10;
  localparam int TXH   = 4;
  localparam int TXP   = 2 * TXH;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txc = 1'b0;
  logic       tx_en = 1'b0;
  logic       send_brk = 1'b0;
  logic       cts_n = 1'b0;
  logic [1:0] baud_sel = 2'b10;
  logic [1:0] len_sel = 2'b11;
  logic       par_en = 1'b1;
  logic       par_even = 1'b1;
  logic [1:0] stop_sel = 2'b01;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, rdy_pin, rdy_stat, tx_empty;

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rst(rst), .txc(txc), .tx_en(tx_en), .send_brk(send_brk),
    .cts_n(cts_n), .baud_sel(baud_sel), .len_sel(len_sel), .par_en(par_en),
    .par_even(par_even), .stop_sel(stop_sel), .wr_stb(wr_stb),
    .wr_data(wr_data), .txd(txd), .rdy_pin(rdy_pin), .rdy_stat(rdy_stat),
    .tx_empty(tx_empty)
  );

  always #(CLK_P/2) clk = ~clk;

  int txc_cnt = 0;
  always @(posedge clk) begin
    if (txc_cnt == TXH - 1) begin
      txc_cnt <= 0;
      txc     <= ~txc;
    end else txc_cnt <= txc_cnt + 1;
  end

  int cyc = 0;
  always @(negedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [7:0] d;
    int nb;
    bit pen;
    bit pev;
    int f;
  } exp_t;

  exp_t q[$];
  int   starts[$];
  int   chk_n = 0;
  int   fail_n = 0;
  bit   mon_on = 1'b1;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic int fac(input logic [1:0] b);
    if (b == 2'b11) return 64;
    if (b == 2'b10) return 16;
    return 1;
  endfunction

  function automatic int stop_len(input logic [1:0] b, input logic [1:0] s);
    int f;
    f = fac(b);
    if (s == 2'b11) return f * 2;
    if (s == 2'b10) return (f == 1) ? 2 : (f * 3) / 2;
    return f;
  endfunction

  // driver: waits for room, pushes the expected frame, writes the character
  task automatic send(input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    while (!rdy_stat) @(negedge clk);
    e.d = d; e.nb = 5 + int'(len_sel); e.pen = par_en; e.pev = par_even;
    e.f = fac(baud_sel);
    q.push_back(e);
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(rdy_stat == 1'b0, "R8 rdy_stat after write", int'(rdy_stat), 0);
    chk(rdy_pin == 1'b0, "R8 rdy_pin after write", int'(rdy_pin), 0);
    if (tx_en && !cts_n)
      chk(tx_empty == 1'b0, "R8 tx_empty after write", int'(tx_empty), 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: decodes frames and compares with the scoreboard queue
  logic prev = 1'b1;
  exp_t m;
  logic [7:0] got;
  int bp;
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && prev && !txd) begin
        starts.push_back(cyc);
        if (q.size() == 0) begin
          chk(1'b0, "R11 unexpected frame", 1, 0);
        end else begin
          m = q.pop_front();
          bp = m.f * TXP;
          got = 8'h00;
          repeat (bp / 2) @(negedge clk);
          chk(txd == 1'b0, "R4 start bit", int'(txd), 0);
          for (int i = 0; i < m.nb; i++) begin
            repeat (bp) @(negedge clk);
            got[i] = txd;
          end
          chk(got == (m.d & ((8'h01 << m.nb) - 8'h01)), "R4 R3 data bits",
              int'(got), int'(m.d & ((8'h01 << m.nb) - 8'h01)));
          if (m.pen) begin
            repeat (bp) @(negedge clk);
            chk((($countones(got) + int'(txd)) % 2) == (m.pev ? 0 : 1),
                "R5 parity bit", int'(txd), m.pev ? 0 : 1);
          end
          repeat (bp) @(negedge clk);
          chk(txd == 1'b1, "R6 stop bit", int'(txd), 1);
        end
      end
      prev = txd;
    end
  end

  task automatic b2b(input logic [1:0] b, input logic [1:0] l, input bit pe,
                     input logic [1:0] s, input logic [7:0] d0, input logic [7:0] d1);
    int expd;
    baud_sel = b; len_sel = l; par_en = pe; stop_sel = s;
    starts.delete();
    send(d0);
    send(d1);
    wait_idle();
    expd = ((1 + 5 + int'(l) + (pe ? 1 : 0)) * fac(b) + stop_len(b, s)) * TXP;
    chk(starts.size() == 2, "R6 two frames seen", starts.size(), 2);
    if (starts.size() == 2)
      chk(starts[1] - starts[0] == expd, "R6 R3 start-to-start spacing",
          starts[1] - starts[0], expd);
    chk(q.size() == 0, "R6 scoreboard drained", q.size(), 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      finish_up();
    end
  end

  int n0;
  bit low_seen;
  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(rdy_stat == 1'b1, "R1 rdy_stat after reset", int'(rdy_stat), 1);
    chk(tx_empty == 1'b1, "R1 tx_empty after reset", int'(tx_empty), 1);
    chk(rdy_pin == 1'b0, "R7 rdy_pin while disabled", int'(rdy_pin), 0);

    tx_en = 1'b1;
    @(negedge clk);
    chk(rdy_pin == 1'b1, "R7 rdy_pin enabled", int'(rdy_pin), 1);
    cts_n = 1'b1;
    @(negedge clk);
    chk(rdy_pin == 1'b0, "R7 rdy_pin with cts high", int'(rdy_pin), 0);
    chk(rdy_stat == 1'b1, "R7 rdy_stat ignores cts", int'(rdy_stat), 1);
    cts_n = 1'b0;

    // 8 bits even parity x16
    send(8'hA5);
    wait_idle();
    chk(tx_empty == 1'b1, "R9 tx_empty after frame", int'(tx_empty), 1);
    chk(txd == 1'b1, "R1 txd idle after frame", int'(txd), 1);
    // 7 bits odd parity
    len_sel = 2'b10; par_even = 1'b0;
    send(8'h6B);
    wait_idle();
    // 5 bits no parity
    len_sel = 2'b00; par_en = 1'b0;
    send(8'h13);
    wait_idle();
    // x1, 6 bits, even parity
    baud_sel = 2'b01; len_sel = 2'b01; par_en = 1'b1; par_even = 1'b1;
    send(8'h2D);
    wait_idle();
    chk(q.size() == 0, "R4 all formats decoded", q.size(), 0);

    // back-to-back frames and stop lengths
    par_even = 1'b0;
    b2b(2'b01, 2'b11, 1'b1, 2'b10, 8'h5A, 8'hC3);
    b2b(2'b10, 2'b10, 1'b1, 2'b10, 8'h11, 8'h7E);
    b2b(2'b11, 2'b11, 1'b0, 2'b11, 8'hF0, 8'h0F);
    b2b(2'b10, 2'b00, 1'b0, 2'b01, 8'h15, 8'h0A);

    // break
    baud_sel = 2'b10; len_sel = 2'b11; par_en = 1'b1; par_even = 1'b1; stop_sel = 2'b01;
    mon_on = 1'b0;
    send_brk = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd == 1'b0, "R2 break drives low", int'(txd), 0);
    repeat (200) @(negedge clk);
    chk(txd == 1'b0, "R2 break held low", int'(txd), 0);
    send_brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R2 line high after break", int'(txd), 1);
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // disable by enable mid-frame
    send(8'h3C);
    while (txd) @(negedge clk);
    tx_en = 1'b0;
    wait_idle();
    chk(q.size() == 0, "R10 frame finished after disable", q.size(), 0);
    chk(txd == 1'b1, "R10 line high after disable", int'(txd), 1);
    chk(tx_empty == 1'b1, "R10 tx_empty after disable", int'(tx_empty), 1);
    tx_en = 1'b1;

    // disable by cts mid-frame
    send(8'hC5);
    while (txd) @(negedge clk);
    cts_n = 1'b1;
    wait_idle();
    chk(q.size() == 0, "R10 frame finished after cts high", q.size(), 0);
    chk(txd == 1'b1, "R10 line high after cts high", int'(txd), 1);
    cts_n = 1'b0;

    // written while disabled by enable
    tx_en = 1'b0;
    n0 = starts.size();
    send(8'h81);
    chk(tx_empty == 1'b1, "R9 tx_empty with held char while disabled", int'(tx_empty), 1);
    low_seen = 1'b0;
    repeat (3000) begin
      @(negedge clk);
      if (!txd) low_seen = 1'b1;
    end
    chk(low_seen == 1'b0, "R11 no output while disabled", int'(low_seen), 0);
    chk(starts.size() == n0, "R11 no frame while disabled", starts.size(), n0);
    tx_en = 1'b1;
    wait_idle();
    chk(q.size() == 0, "R11 held char sent after enable", q.size(), 0);

    // written while cts high
    cts_n = 1'b1;
    n0 = starts.size();
    send(8'h4E);
    repeat (3000) @(negedge clk);
    chk(starts.size() == n0, "R11 no frame while cts high", starts.size(), n0);
    chk(rdy_stat == 1'b0, "R7 rdy_stat stays low with held char", int'(rdy_stat), 0);
    cts_n = 1'b0;
    wait_idle();
    chk(q.size() == 0, "R11 held char sent after cts low", q.size(), 0);
    chk(rdy_stat == 1'b1, "R7 rdy_stat after drain", int'(rdy_stat), 1);

    done = 1'b1;
    finish_up();
  end

endmodule